// File: doc/BRIEF.md
# JTAG Test Access Port Controller

This block is the test access port of a chip. It runs on the test clock `tck` and is steered only by the mode-select input `tms`. An optional active-low `trst_n` resets it asynchronously. It holds the sixteen-state TAP state machine, a parameter-wide instruction register and a one-bit bypass register. It decodes the active instruction into three kinds of control:

- a data-register select;
- the capture, shift and update strobes for the boundary cells;
- a pin-control mode, a pin-disable flag and a self-test run flag.

The boundary register and the self-test engine are outside the block. Each feeds its serial output back through `bsr_so` or `bist_so` and takes its serial input directly from `tdi`. The block drives `tdo` from the instruction register in Shift-IR and from the selected data register in Shift-DR. `tdo` changes on the falling edge of `tck`, and `tdo_en` marks when the pin is driven.

The seven instructions are bypass, extest, sample, intest, clamp, high-Z and run-self-test. Clamp and high-Z put the one-bit bypass register in the scan path while the pins are held. Under clamp the pins follow the boundary register's held contents. Under high-Z they are disabled.

Top module: `tap_ctrl`

## Requirements
- R1: Driving `trst_n` low puts the controller into Test-Logic-Reset at once, without a `tck` edge. While held there, `tap_reset`=1, `tdo_en`=0, `dr_sel`=0, and `bsr_mode`, `pins_off` and `bist_run` are all 0.
- R2: From any state, five consecutive rising `tck` edges with `tms`=1 bring the controller to Test-Logic-Reset (`tap_reset`=1). Four such edges from Shift-DR do not.
- R3: From Shift-DR, the `tms` sequence 1,0,1,0 goes through Exit1, Pause and Exit2 back to Shift-DR. `shift_dr` and `clock_dr` are 0 in the three middle states, return to 1 in Shift-DR, and no capture occurs on the way.
- R4: In Capture-DR, `clock_dr`=1 and `shift_dr`=0. In Shift-DR, `clock_dr`=1 and `shift_dr`=1. In Update-DR, `update_dr`=1. In Run-Test/Idle all three are 0.
- R5: Capture-IR loads the pattern ...0001 into the instruction shift register. In Shift-IR it leaves on `tdo` least significant bit first, so the first two bits seen are 1 then 0. Instruction codes are shifted in least significant bit first and take effect on leaving Update-IR.
- R6: Entering Test-Logic-Reset makes bypass (code all ones) the active instruction. The bypass register captures 0. In Shift-DR it delays `tdi` by one `tck` cycle to `tdo`.
- R7: Codes other than the seven defined ones act as bypass: `dr_sel`=0, and `bsr_mode`, `pins_off` and `bist_run` are all 0.
- R8: Clamp (code 3) gives `bsr_mode`=1, `pins_off`=0 and `dr_sel`=0. High-Z (code 4) gives `pins_off`=1 and `dr_sel`=0. Under both, Shift-DR shows the bypass register on `tdo`, not `bsr_so`.
- R9: Extest (code 0) and intest (code 2) give `dr_sel`=1 and `bsr_mode`=1. Sample (code 1) gives `dr_sel`=1 and `bsr_mode`=0.
- R10: Run-self-test (code 5) gives `dr_sel`=2. `bist_run` is 1 only while the controller sits in Run-Test/Idle under that instruction.
- R11: `tdo` and `tdo_en` change only on the falling edge of `tck`. `tdo_en` is 1 exactly in the half cycles that follow a falling edge in Shift-IR or Shift-DR.
- R12: In Shift-DR, `tdo` carries `bsr_so` when `dr_sel`=1 and `bist_so` when `dr_sel`=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select steering the state machine |
| tdi | input | 1 | Serial test data in |
| bsr_so | input | 1 | Serial output of the external boundary register |
| bist_so | input | 1 | Serial output of the external self-test result register |
| tdo | output | 1 | Serial test data out, falling-edge timed |
| tdo_en | output | 1 | Output enable for the `tdo` pad |
| tap_reset | output | 1 | High in Test-Logic-Reset (functional mode) |
| dr_sel | output | 2 | Selected data register: 0 bypass, 1 boundary, 2 self-test |
| clock_dr | output | 1 | Data-register clock enable (capture or shift) |
| shift_dr | output | 1 | Shift (1) versus parallel capture (0) |
| update_dr | output | 1 | Transfer shifted data to the boundary outputs |
| bsr_mode | output | 1 | Pins driven from the boundary register's held contents |
| pins_off | output | 1 | All device outputs disabled |
| bist_run | output | 1 | Self-test engine may run |

## Verification
The bench builds the controller with a four-bit instruction register, which is the default. At that width the seven defined codes leave nine spare codes, so the fall-back to bypass can be tried with an arbitrary spare value. The captured ...01 pattern is also short enough to be checked bit by bit on `tdo`. Every instruction is loaded through a full Capture-IR, Shift-IR and Update-IR walk. The bypass, boundary and self-test paths are each then exercised in Shift-DR, together with the pause loop and both ways into reset.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

    // Sixteen controller states
    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
    } tap_state_e;

    // Decoded operations
    typedef enum logic [2:0] {
        OP_BYPASS, OP_EXTEST, OP_SAMPLE, OP_INTEST, OP_CLAMP, OP_HIGHZ, OP_RUNBIST
    } tap_op_e;

    // Data register selection, visible on dr_sel
    typedef enum logic [1:0] {
        DR_BYP  = 2'd0,
        DR_BSR  = 2'd1,
        DR_BIST = 2'd2
    } dr_sel_e;

    // Per-register phase strobes
    typedef struct packed {
        logic capture;
        logic shift;
        logic update;
    } tap_step_t;

    // Instruction decode result
    typedef struct packed {
        dr_sel_e sel;
        logic    mode;
        logic    pins_off;
        logic    bist_en;
    } tap_dec_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        tap_state_e n;
        case (s)
            TS_RESET:  n = m ? TS_RESET  : TS_IDLE;
            TS_IDLE:   n = m ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: n = m ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: n = m ? TS_EX1_DR : TS_SHF_DR;
            TS_SHF_DR: n = m ? TS_EX1_DR : TS_SHF_DR;
            TS_EX1_DR: n = m ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: n = m ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: n = m ? TS_UPD_DR : TS_SHF_DR;
            TS_UPD_DR: n = m ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: n = m ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: n = m ? TS_EX1_IR : TS_SHF_IR;
            TS_SHF_IR: n = m ? TS_EX1_IR : TS_SHF_IR;
            TS_EX1_IR: n = m ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: n = m ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: n = m ? TS_UPD_IR : TS_SHF_IR;
            TS_UPD_IR: n = m ? TS_SEL_DR : TS_IDLE;
            default:   n = TS_RESET;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state,
    output tap_state_e state_nxt,
    output tap_step_t  dr_step,
    output tap_step_t  ir_step
);

    always_comb state_nxt = tap_next(state, tms);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= TS_RESET;
        else         state <= state_nxt;
    end

    always_comb begin
        dr_step.capture = (state == TS_CAP_DR);
        dr_step.shift   = (state == TS_SHF_DR);
        dr_step.update  = (state == TS_UPD_DR);
        ir_step.capture = (state == TS_CAP_IR);
        ir_step.shift   = (state == TS_SHF_IR);
        ir_step.update  = (state == TS_UPD_IR);
    end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import jtag_tap_pkg::*;
#(
    parameter int IR_W = 4
) (
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tdi,
    input  tap_step_t  ir_step,
    input  tap_state_e state_nxt,
    output tap_op_e    op,
    output logic       ir_so
);

    localparam logic [IR_W-1:0] C_EXTEST  = IR_W'(0);
    localparam logic [IR_W-1:0] C_SAMPLE  = IR_W'(1);
    localparam logic [IR_W-1:0] C_INTEST  = IR_W'(2);
    localparam logic [IR_W-1:0] C_CLAMP   = IR_W'(3);
    localparam logic [IR_W-1:0] C_HIGHZ   = IR_W'(4);
    localparam logic [IR_W-1:0] C_RUNBIST = IR_W'(5);
    localparam logic [IR_W-1:0] C_BYPASS  = '1;
    localparam logic [IR_W-1:0] C_CAPTURE = IR_W'(1);

    logic [IR_W-1:0] ir_sh;
    logic [IR_W-1:0] ir_code;

    // Shift stage: capture fixed pattern, shift LSB out first
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)              ir_sh <= C_CAPTURE;
        else if (ir_step.capture) ir_sh <= C_CAPTURE;
        else if (ir_step.shift)   ir_sh <= {tdi, ir_sh[IR_W-1:1]};
    end

    // Active instruction: bypass on entry to reset, else take on update
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                    ir_code <= C_BYPASS;
        else if (state_nxt == TS_RESET) ir_code <= C_BYPASS;
        else if (ir_step.update)        ir_code <= ir_sh;
    end

    always_comb begin
        case (ir_code)
            C_EXTEST:  op = OP_EXTEST;
            C_SAMPLE:  op = OP_SAMPLE;
            C_INTEST:  op = OP_INTEST;
            C_CLAMP:   op = OP_CLAMP;
            C_HIGHZ:   op = OP_HIGHZ;
            C_RUNBIST: op = OP_RUNBIST;
            default:   op = OP_BYPASS;
        endcase
    end

    assign ir_so = ir_sh[0];

endmodule

// File: rtl/tap_decode.sv
module tap_decode
    import jtag_tap_pkg::*;
(
    input  tap_op_e    op,
    input  tap_state_e state,
    output tap_dec_t   dec
);

    always_comb begin
        dec.sel      = DR_BYP;
        dec.mode     = 1'b0;
        dec.pins_off = 1'b0;
        dec.bist_en  = 1'b0;
        case (op)
            OP_EXTEST, OP_INTEST: begin
                dec.sel  = DR_BSR;
                dec.mode = 1'b1;
            end
            OP_SAMPLE:  dec.sel = DR_BSR;
            OP_CLAMP:   dec.mode = 1'b1;
            OP_HIGHZ:   dec.pins_off = 1'b1;
            OP_RUNBIST: begin
                dec.sel     = DR_BIST;
                dec.bist_en = (state == TS_IDLE);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/tap_dr_path.sv
module tap_dr_path
    import jtag_tap_pkg::*;
(
    input  logic      tck,
    input  logic      trst_n,
    input  logic      tdi,
    input  tap_step_t dr_step,
    input  tap_step_t ir_step,
    input  dr_sel_e   sel,
    input  logic      ir_so,
    input  logic      bsr_so,
    input  logic      bist_so,
    output logic      tdo,
    output logic      tdo_en
);

    logic byp_q;
    logic dr_so;
    logic so_nxt;
    logic shifting;

    // One-bit bypass register
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                                 byp_q <= 1'b0;
        else if (sel == DR_BYP && dr_step.capture)   byp_q <= 1'b0;
        else if (sel == DR_BYP && dr_step.shift)     byp_q <= tdi;
    end

    always_comb begin
        case (sel)
            DR_BSR:  dr_so = bsr_so;
            DR_BIST: dr_so = bist_so;
            default: dr_so = byp_q;
        endcase
    end

    assign shifting = dr_step.shift | ir_step.shift;
    assign so_nxt   = ir_step.shift ? ir_so : dr_so;

    // Falling-edge output stage
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= shifting;
            if (shifting) tdo <= so_nxt;
        end
    end

endmodule

// File: rtl/tap_ctrl.sv
module tap_ctrl
    import jtag_tap_pkg::*;
#(
    parameter int IR_W = 4
) (
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    input  logic       tdi,
    input  logic       bsr_so,
    input  logic       bist_so,
    output logic       tdo,
    output logic       tdo_en,
    output logic       tap_reset,
    output logic [1:0] dr_sel,
    output logic       clock_dr,
    output logic       shift_dr,
    output logic       update_dr,
    output logic       bsr_mode,
    output logic       pins_off,
    output logic       bist_run
);

    tap_state_e st;
    tap_state_e st_nxt;
    tap_step_t  dr_step;
    tap_step_t  ir_step;
    tap_op_e    op;
    logic       ir_so;
    tap_dec_t   dec;

    tap_fsm i_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms),
        .state(st), .state_nxt(st_nxt),
        .dr_step(dr_step), .ir_step(ir_step)
    );

    tap_ir #(.IR_W(IR_W)) i_ir (
        .tck(tck), .trst_n(trst_n), .tdi(tdi),
        .ir_step(ir_step), .state_nxt(st_nxt),
        .op(op), .ir_so(ir_so)
    );

    tap_decode i_dec (
        .op(op), .state(st), .dec(dec)
    );

    tap_dr_path i_path (
        .tck(tck), .trst_n(trst_n), .tdi(tdi),
        .dr_step(dr_step), .ir_step(ir_step), .sel(dec.sel),
        .ir_so(ir_so), .bsr_so(bsr_so), .bist_so(bist_so),
        .tdo(tdo), .tdo_en(tdo_en)
    );

    assign tap_reset = (st == TS_RESET);
    assign dr_sel    = dec.sel;
    assign clock_dr  = dr_step.capture | dr_step.shift;
    assign shift_dr  = dr_step.shift;
    assign update_dr = dr_step.update;
    assign bsr_mode  = dec.mode;
    assign pins_off  = dec.pins_off;
    assign bist_run  = dec.bist_en;

endmodule

// File: rtl/tap_ctrl_chk.sv
module tap_ctrl_chk
    import jtag_tap_pkg::*;
(
    input logic       tck,
    input logic       trst_n,
    input logic       tms,
    input tap_state_e state,
    input logic       tdo_en,
    input logic       tap_reset,
    input logic [1:0] dr_sel,
    input logic       clock_dr,
    input logic       shift_dr,
    input logic       update_dr,
    input logic       bsr_mode,
    input logic       pins_off,
    input logic       bist_run
);

    logic [2:0] ones;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)         ones <= 3'd0;
        else if (!tms)       ones <= 3'd0;
        else if (ones != 3'd5) ones <= ones + 3'd1;
    end

    a_r2_five_ones: assert property (@(posedge tck) disable iff (!trst_n)
        (ones == 3'd5) |-> tap_reset);

    a_r4_strobes_exclusive: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({clock_dr, update_dr}) && (shift_dr -> clock_dr));

    a_r4_update_then_no_clock: assert property (@(posedge tck) disable iff (!trst_n)
        update_dr |=> !clock_dr);

    a_r6_reset_is_bypass: assert property (@(posedge tck) disable iff (!trst_n)
        tap_reset |-> (dr_sel == 2'd0 && !bsr_mode && !pins_off && !bist_run));

    a_r8_highz_uses_bypass: assert property (@(posedge tck) disable iff (!trst_n)
        pins_off |-> (dr_sel == 2'd0));

    a_r10_bist_only_idle: assert property (@(posedge tck) disable iff (!trst_n)
        bist_run |-> (state == TS_IDLE && dr_sel == 2'd2));

    a_r11_tdo_en_window: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en == (state == TS_SHF_DR || state == TS_SHF_IR));

endmodule

bind tap_ctrl tap_ctrl_chk i_chk (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state(st),
    .tdo_en(tdo_en), .tap_reset(tap_reset), .dr_sel(dr_sel),
    .clock_dr(clock_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .bsr_mode(bsr_mode), .pins_off(pins_off), .bist_run(bist_run)
);

// File: tb/test_tap_ctrl.sv
module test_tap_ctrl;

    localparam int IR_W = 4;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic bsr_so = 1'b0;
    logic bist_so = 1'b0;
    logic tdo, tdo_en, tap_reset, clock_dr, shift_dr, update_dr;
    logic bsr_mode, pins_off, bist_run;
    logic [1:0] dr_sel;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic ir_first, ir_second;

    always #2 tck = ~tck;

    tap_ctrl #(.IR_W(IR_W)) i_tap_ctrl (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .bsr_so(bsr_so), .bist_so(bist_so),
        .tdo(tdo), .tdo_en(tdo_en), .tap_reset(tap_reset), .dr_sel(dr_sel),
        .clock_dr(clock_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .bsr_mode(bsr_mode), .pins_off(pins_off), .bist_run(bist_run)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One tck cycle; returns 1 ns after the falling edge
    task automatic step(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    // From Run-Test/Idle, load a code and return to Run-Test/Idle
    task automatic load_ir(input logic [IR_W-1:0] code);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        ir_first = tdo;
        for (int i = 0; i < IR_W; i++) begin
            step(i == IR_W - 1, code[i]);
            if (i == 0) ir_second = tdo;
        end
        step(1, 0); step(0, 0);
    endtask

    task automatic to_shift_dr();
        step(1, 0); step(0, 0); step(0, 0);
    endtask

    task automatic leave_shift_dr();
        step(1, 0); step(1, 0); step(0, 0);
    endtask

    task automatic t_reset_state();
        chk("R1 reset tap_reset", tap_reset, 1);
        chk("R1 reset tdo_en", tdo_en, 0);
        chk("R1 reset dr_sel", dr_sel, 0);
        chk("R1 reset mode/off/bist", {bsr_mode, pins_off, bist_run}, 0);
        trst_n = 1'b1;
        step(0, 0);
        chk("R1 idle after release", tap_reset, 0);
    endtask

    task automatic t_extest_and_strobes();
        load_ir(IR_W'(0));
        chk("R5 ir capture bit0", ir_first, 1);
        chk("R5 ir capture bit1", ir_second, 0);
        chk("R9 extest sel", dr_sel, 1);
        chk("R9 extest mode", bsr_mode, 1);
        chk("R4 idle strobes", {clock_dr, shift_dr, update_dr}, 0);
        chk("R11 idle tdo_en", tdo_en, 0);
        bsr_so = 1'b1;
        step(1, 0); step(0, 0);
        chk("R4 capture strobes", {clock_dr, shift_dr}, 2'b10);
        step(0, 0);
        chk("R4 shift strobes", {clock_dr, shift_dr}, 2'b11);
        chk("R12 tdo from boundary", tdo, 1);
        chk("R11 tdo_en in shift", tdo_en, 1);
        step(1, 0); step(1, 0);
        chk("R4 update strobe", update_dr, 1);
        step(0, 0);
        bsr_so = 1'b0;
    endtask

    task automatic t_pause_loop();
        to_shift_dr();
        step(1, 0);
        chk("R3 exit1 no shift", {clock_dr, shift_dr}, 0);
        step(0, 0);
        chk("R3 pause no shift", {clock_dr, shift_dr}, 0);
        step(1, 0);
        chk("R3 exit2 no shift", {clock_dr, shift_dr}, 0);
        step(0, 0);
        chk("R3 back in shift", {clock_dr, shift_dr}, 2'b11);
        leave_shift_dr();
    endtask

    task automatic t_sample_intest();
        load_ir(IR_W'(1));
        chk("R9 sample sel/mode", {dr_sel, bsr_mode}, {2'd1, 1'b0});
        load_ir(IR_W'(2));
        chk("R9 intest sel/mode", {dr_sel, bsr_mode}, {2'd1, 1'b1});
    endtask

    task automatic t_bypass();
        load_ir('1);
        chk("R6 bypass sel", dr_sel, 0);
        to_shift_dr();
        chk("R6 bypass captures 0", tdo, 0);
        tms = 0; tdi = 1;
        @(posedge tck); #1;
        chk("R11 tdo held at rising edge", tdo, 0);
        @(negedge tck); #1;
        chk("R6 bypass delay bit0", tdo, 1);
        step(0, 0);
        chk("R6 bypass delay bit1", tdo, 0);
        step(0, 1);
        chk("R6 bypass delay bit2", tdo, 1);
        step(1, 0);
        chk("R11 tdo_en off after shift", tdo_en, 0);
        step(1, 0); step(0, 0);
    endtask

    task automatic t_clamp_highz();
        load_ir(IR_W'(3));
        chk("R8 clamp decode", {dr_sel, bsr_mode, pins_off}, {2'd0, 1'b1, 1'b0});
        bsr_so = 1'b1;
        to_shift_dr();
        chk("R8 clamp tdo is bypass", tdo, 0);
        leave_shift_dr();
        load_ir(IR_W'(4));
        chk("R8 highz decode", {dr_sel, pins_off}, {2'd0, 1'b1});
        to_shift_dr();
        chk("R8 highz tdo is bypass", tdo, 0);
        leave_shift_dr();
        bsr_so = 1'b0;
    endtask

    task automatic t_runbist();
        load_ir(IR_W'(5));
        chk("R10 runbist sel", dr_sel, 2);
        chk("R10 run in idle", bist_run, 1);
        step(1, 0);
        chk("R10 stop outside idle", bist_run, 0);
        bist_so = 1'b1;
        step(0, 0); step(0, 0);
        chk("R12 tdo from self-test", tdo, 1);
        leave_shift_dr();
        bist_so = 1'b0;
    endtask

    task automatic t_unknown();
        load_ir(IR_W'(10));
        chk("R7 spare code decode", {dr_sel, bsr_mode, pins_off, bist_run}, 0);
    endtask

    task automatic t_five_ones();
        load_ir(IR_W'(0));
        to_shift_dr();
        for (int i = 0; i < 4; i++) step(1, 0);
        chk("R2 four ones not reset", tap_reset, 0);
        step(1, 0);
        chk("R2 five ones reset", tap_reset, 1);
        chk("R6 reset loads bypass", {dr_sel, bsr_mode}, 0);
        step(0, 0);
    endtask

    task automatic t_async();
        load_ir(IR_W'(2));
        @(posedge tck); #1;
        trst_n = 1'b0;
        #0.5;
        chk("R1 async tap_reset", tap_reset, 1);
        chk("R1 async mode cleared", bsr_mode, 0);
        @(negedge tck); #1;
        trst_n = 1'b1;
        step(0, 0);
    endtask

    initial begin
        @(negedge tck); #1;
        t_reset_state();
        t_extest_and_strobes();
        t_pause_loop();
        t_sample_intest();
        t_bypass();
        t_clamp_highz();
        t_runbist();
        t_unknown();
        t_five_ones();
        t_async();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge tck);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule